// File: doc/BRIEF.md
# Four-Byte I2C Write Sequencer

This block performs one complete I2C write transaction each time it is started. It drives open-drain SCL and SDA through active-high pull-down enables. A transaction sends a START condition, a device byte, two register-address bytes and two data bytes, then a STOP condition. The device byte is sent exactly as supplied, so its least significant bit is the read/write flag. Each byte is followed by an acknowledge slot, and the block samples the line in that slot.

A missing acknowledge on any byte ends the transaction at once. The block releases both lines and does not send STOP. It raises an error flag and reports how many phases had completed. A phase is START or any acknowledged byte. All five operand bytes and the divider setting are captured when a start is accepted. The caller may therefore change them while a transaction is running. Arbitration, clock stretching and reads are not supported.

Top module: `i2c_quad_writer`

## Requirements
- R1: After reset, both line enables, busy, done and err are 0, and err_phase is 0.
- R2: A one-cycle `go` while idle starts a transaction, and busy is 1 from the next cycle until the transaction ends. A `go` that arrives while busy has no effect on the bytes sent, the timing or the number of transactions.
- R3: A transaction begins with SDA falling while SCL is high. It then sends `dev_addr` unchanged (bit 0 is the R/W flag), followed by `reg_hi`, `reg_lo`, `val_hi` and `val_lo`, in that order.
- R4: Bits go out MSB first on eight SCL pulses. On the ninth pulse the block releases SDA and samples it, where low means acknowledge.
- R5: The SCL period is 4 × `div_cnt` system clocks, with the value captured at start. A `div_cnt` of 0 behaves as 1.
- R6: SDA changes only while SCL is low. The only exceptions are the START fall and the STOP rise.
- R7: After the fifth acknowledge the block sends STOP, with SDA rising while SCL is high. done is then high for exactly one cycle while err stays 0.
- R8: A NACK ends the transaction right after that acknowledge slot. Both lines are released, no STOP is sent, busy drops, and err stays 1 until the next accepted start.
- R9: err_phase gives the number of completed phases: 1 for START plus 1 for each acknowledged byte. A NACK on byte k (device byte is k=0) therefore reports k+1, which ranges from 1 to 5.
- R10: An accepted start clears err and err_phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start request, one cycle |
| div_cnt | input | DIV_W | Quarter-bit length in clocks |
| dev_addr | input | 8 | Device byte including R/W bit |
| reg_hi | input | 8 | Register address, high byte |
| reg_lo | input | 8 | Register address, low byte |
| val_hi | input | 8 | Data, high byte |
| val_lo | input | 8 | Data, low byte |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | Last transaction ended on NACK |
| err_phase | output | 3 | Phases completed before NACK |

## Verification
The bench builds the block with the default DIV_W of 12 and drives divider values of 0, 2, 3 and 5. These short bit times keep each full transaction under about a thousand cycles. The bench can then run several successful writes, NACKs on the first, fourth and fifth bytes, and a start request injected mid-transfer with a different divider. The mid-transfer case shows whether the captured divider and bytes really stay fixed. A bus model on the bench side decodes START, STOP, bytes and SCL periods, and it acknowledges or refuses each byte as the test script directs.

// File: rtl/i2c_quad_writer.sv
module i2c_quad_writer #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DIV_W-1:0] div_cnt,
  input  logic [7:0]       dev_addr,
  input  logic [7:0]       reg_hi,
  input  logic [7:0]       reg_lo,
  input  logic [7:0]       val_hi,
  input  logic [7:0]       val_lo,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_phase
);
  localparam int NBYTE = 5;
  localparam int BCW   = $clog2(NBYTE);
  localparam int ACKB  = 8;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_q, dcnt;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [BCW-1:0]   byten;
  logic [2:0]       phase;
  logic [7:0]       sh;
  logic             nack;
  logic [7:0]       buf_q [NBYTE];

  wire              tick  = (dcnt == div_q - 1'b1);
  wire              ack_b = (bitn == 4'(ACKB));
  wire [BCW-1:0]    nxt_i = byten + 1'b1;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      div_q     <= {{(DIV_W-1){1'b0}}, 1'b1};
      dcnt      <= '0;
      q         <= '0;
      bitn      <= '0;
      byten     <= '0;
      phase     <= '0;
      sh        <= '0;
      nack      <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_phase <= '0;
      for (int i = 0; i < NBYTE; i++) buf_q[i] <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (go) begin
          st        <= S_START;
          div_q     <= (div_cnt == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_cnt;
          buf_q[0]  <= dev_addr;
          buf_q[1]  <= reg_hi;
          buf_q[2]  <= reg_lo;
          buf_q[3]  <= val_hi;
          buf_q[4]  <= val_lo;
          dcnt      <= '0;
          q         <= '0;
          bitn      <= '0;
          byten     <= '0;
          phase     <= '0;
          err       <= 1'b0;
          err_phase <= '0;
        end
      end else if (!tick) begin
        dcnt <= dcnt + 1'b1;
      end else begin
        dcnt <= '0;
        q    <= q + 2'd1;
        case (st)
          S_START: begin
            if (q == 2'd1) sda_oe <= 1'b1;
            if (q == 2'd3) begin
              st     <= S_BIT;
              scl_oe <= 1'b1;
              phase  <= 3'd1;
              sh     <= buf_q[0];
              bitn   <= '0;
            end
          end
          S_BIT: begin
            case (q)
              2'd0: sda_oe <= ack_b ? 1'b0 : ~sh[7];
              2'd1: scl_oe <= 1'b0;
              2'd2: if (ack_b) nack <= sda_in;
              2'd3: begin
                if (!ack_b) begin
                  scl_oe <= 1'b1;
                  sh     <= {sh[6:0], 1'b0};
                  bitn   <= bitn + 4'd1;
                end else if (nack) begin
                  st        <= S_IDLE;
                  sda_oe    <= 1'b0;
                  err       <= 1'b1;
                  err_phase <= phase;
                end else begin
                  scl_oe <= 1'b1;
                  phase  <= phase + 3'd1;
                  bitn   <= '0;
                  if (byten == BCW'(NBYTE - 1)) begin
                    st <= S_STOP;
                  end else begin
                    byten <= nxt_i;
                    sh    <= buf_q[nxt_i];
                  end
                end
              end
              default: ;
            endcase
          end
          S_STOP: begin
            case (q)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd3: begin
                sda_oe <= 1'b0;
                st     <= S_IDLE;
                done   <= 1'b1;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  p_go_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);

  p_sda_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st) == S_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!err && !busy));

  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  p_err_phase_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_phase >= 3'd1 && err_phase <= 3'd5));

  p_err_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !busy && !go) |=> err);
endmodule

// File: tb/i2c_quad_writer_tb.sv
module i2c_quad_writer_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 12;

  logic          clk = 0, rst_n = 0, go = 0;
  logic [DW-1:0] div_cnt = 2;
  logic [7:0]    dev_addr = 0, reg_hi = 0, reg_lo = 0, val_hi = 0, val_lo = 0;
  logic          sda_in, scl_oe, sda_oe, busy, done, err;
  logic [2:0]    err_phase;

  int   n_chk = 0, n_err = 0;
  logic pull = 0;
  logic mon_clr = 0;
  int   nack_at = -1;
  int   cyc = 0;
  int   nstart, nstop, nrx, bitc, done_cnt, last_rise, per_min, per_max;
  logic [7:0] rxb [6];
  logic [7:0] msh;
  logic prev_scl = 1, prev_sda = 1;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc++;

  assign sda_in = !(sda_oe || pull);

  i2c_quad_writer #(.DIV_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .div_cnt(div_cnt),
    .dev_addr(dev_addr), .reg_hi(reg_hi), .reg_lo(reg_lo),
    .val_hi(val_hi), .val_lo(val_lo), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .err(err), .err_phase(err_phase));

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = !scl_oe;
    sda_l = !(sda_oe || pull);
    if (mon_clr) begin
      pull = 0; nstart = 0; nstop = 0; nrx = 0; bitc = 0; done_cnt = 0;
      last_rise = -1; per_min = 1 << 30; per_max = 0; msh = 0;
      for (int i = 0; i < 6; i++) rxb[i] = 0;
    end else begin
      if (scl_l && prev_scl) begin
        if (prev_sda && !sda_l) begin nstart++; bitc = 0; end
        if (!prev_sda && sda_l) nstop++;
      end
      if (scl_l && !prev_scl) begin
        msh = {msh[6:0], sda_l};
        bitc++;
        if (last_rise >= 0) begin
          if (cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
        if (bitc == 8) begin
          if (nrx < 6) rxb[nrx] = msh;
          nrx++;
        end
      end
      if (!scl_l && prev_scl) begin
        if (bitc == 8) pull = ((nrx - 1) != nack_at);
        else if (bitc == 9) begin pull = 0; bitc = 0; end
      end
      if (done) done_cnt++;
    end
    prev_scl = scl_l;
    prev_sda = !(sda_oe || pull);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_tx(input logic [7:0] a, b, c, d, e, input int dv, input int nk);
    @(negedge clk);
    dev_addr = a; reg_hi = b; reg_lo = c; val_hi = d; val_lo = e;
    div_cnt = DW'(dv); nack_at = nk;
    @(posedge clk); mon_clr = 1;
    @(posedge clk); mon_clr = 0;
    @(negedge clk); go = 1;
    @(negedge clk); go = 0;
    chk(busy == 1, "R2 busy after go", int'(busy), 1);
    chk(err == 0, "R10 err cleared by start", int'(err), 0);
    chk(err_phase == 0, "R10 err_phase cleared", int'(err_phase), 0);
  endtask

  task automatic wait_tx();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    chk(busy == 0, "R2 transaction ends", int'(busy), 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_ok(input logic [7:0] a, b, c, d, e, input int dv);
    logic [7:0] exp [5];
    exp[0] = a; exp[1] = b; exp[2] = c; exp[3] = d; exp[4] = e;
    chk(nstart == 1, "R3 one START", nstart, 1);
    chk(nrx == 5, "R3 byte count", nrx, 5);
    for (int i = 0; i < 5; i++)
      chk(rxb[i] == exp[i], "R3 R4 byte order and MSB first", int'(rxb[i]), int'(exp[i]));
    chk(nstop == 1, "R7 one STOP and R6 no stray edges", nstop, 1);
    chk(done_cnt == 1, "R7 done one cycle", done_cnt, 1);
    chk(err == 0, "R7 no error", int'(err), 0);
    chk(per_min == 4 * dv && per_max == 4 * dv, "R5 SCL period", per_max, 4 * dv);
    chk(!scl_oe && !sda_oe, "R8 lines released when idle", int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic t_reset();
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", int'({scl_oe, sda_oe}), 0);
    chk(busy == 0 && done == 0, "R1 busy/done low", int'({busy, done}), 0);
    chk(err == 0 && err_phase == 0, "R1 err clear", int'(err_phase), 0);
  endtask

  task automatic t_write(input logic [7:0] a, b, c, d, e, input int dv);
    start_tx(a, b, c, d, e, dv, -1);
    wait_tx();
    check_ok(a, b, c, d, e, dv);
  endtask

  task automatic t_div_zero();
    start_tx(8'h3C, 8'h01, 8'h80, 8'hFF, 8'h00, 0, -1);
    wait_tx();
    check_ok(8'h3C, 8'h01, 8'h80, 8'hFF, 8'h00, 1);
  endtask

  task automatic t_nack(input int k);
    start_tx(8'h91, 8'h5A, 8'hC3, 8'h0F, 8'hF0, 2, k);
    wait_tx();
    chk(err == 1, "R8 err on NACK", int'(err), 1);
    chk(err_phase == 3'(k + 1), "R9 err_phase", int'(err_phase), k + 1);
    chk(nstop == 0, "R8 no STOP after NACK", nstop, 0);
    chk(nrx == k + 1, "R4 R8 bytes before abort", nrx, k + 1);
    chk(done_cnt == 0, "R8 no done on NACK", done_cnt, 0);
    chk(!scl_oe && !sda_oe, "R8 lines released", int'({scl_oe, sda_oe}), 0);
    repeat (50) @(negedge clk);
    chk(err == 1, "R8 err held while idle", int'(err), 1);
  endtask

  task automatic t_busy_ignore();
    start_tx(8'hB6, 8'h12, 8'h34, 8'h56, 8'h78, 3, -1);
    repeat (120) @(negedge clk);
    dev_addr = 8'h00; reg_hi = 8'hEE; reg_lo = 8'hDD; val_hi = 8'hCC; val_lo = 8'hBB;
    div_cnt = 7;
    go = 1;
    @(negedge clk); go = 0;
    wait_tx();
    check_ok(8'hB6, 8'h12, 8'h34, 8'h56, 8'h78, 3);
    repeat (200) @(negedge clk);
    chk(nstart == 1 && busy == 0, "R2 go while busy ignored", nstart, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write(8'hA5, 8'h12, 8'h34, 8'h56, 8'h78, 2);
    t_write(8'h4E, 8'hFF, 8'h00, 8'h81, 8'h7E, 5);
    t_div_zero();
    t_nack(0);
    t_write(8'h40, 8'h11, 8'h22, 8'h33, 8'h44, 2);
    t_nack(3);
    t_nack(4);
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule